// File: doc/BRIEF.md
# Boot ROM Overlay and Power-Up Load Controller

This block sits beside a 16-bit processor that has a non-maskable load interrupt. It decides whether a bus access near one end of the address space goes to a small boot ROM or to RAM. It also raises the load interrupt that starts execution through the vector inside that ROM. After power-on, the ROM is laid over a window of `2**WIN_BITS` bytes at the top of memory, and a one-cycle load request follows. The window covers 0xFC00 through 0xFFFF in the default configuration, including the vector word at 0xFFFC. Once the processor signals that its memory mapper is in use, the window is removed. From then on the same addresses reach paged RAM, which leaves the vector area free for user code.

A front-panel load button brings the ROM window back and then requests the load interrupt. This gives a cold restart from a lock-up without a full reset. The raw button is synchronised and must hold steady for `DEB_CYCLES` clocks before it counts. A strap input moves the ROM window to the bottom of memory. RAM then fills every other address.

Top module: `boot_map_ctrl`

## Requirements
- R1: Starting from reset, the ROM window is open and `load_irq` is low. On the first rising clock edge after `rst_n` goes high, `load_irq` rises for exactly one cycle.
- R2: With `map_low` = 0, the window open and `psel` low, an access with `mem_en` high selects ROM when `addr[15:10]` = 6'h3F (0xFC00 to 0xFFFF). Every other address selects RAM.
- R3: While `psel` is high, an access inside the window selects RAM, and `rom_cs` stays low in the same cycle.
- R4: The window closes at the first rising edge at which `mem_en` and `psel` are both high. After that, window addresses select RAM even with `psel` low, until the next press.
- R5: With `map_low` = 1, the window is `addr[15:10]` = 6'h00 (0x0000 to 0x03FF). All other addresses, 0xFC00 to 0xFFFF included, select RAM.
- R6: While `mem_en` is low, both `rom_cs` and `ram_cs` are low.
- R7: A button press counts once the synchronised level differs from the settled level for `DEB_CYCLES` consecutive edges. The window reopens at edge `DEB_CYCLES`+3 after the raw input rises, and `load_irq` is high for exactly one cycle after edge `DEB_CYCLES`+4.
- R8: A button pulse shorter than `DEB_CYCLES` cycles has no effect: no load request, and the window stays closed.
- R9: Releasing the button produces no load request and does not change the window.
- R10: `rom_cs` and `ram_cs` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| load_btn | input | 1 | Raw front-panel load button, active high, asynchronous |
| map_low | input | 1 | Strap: 0 places ROM at the top, 1 places it at the bottom |
| mem_en | input | 1 | Bus memory-cycle enable |
| psel | input | 1 | Mapper-enable status from the processor |
| addr | input | 16 | Byte address of the current access |
| rom_cs | output | 1 | Boot ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| load_irq | output | 1 | One-cycle registered load-interrupt request |

## Verification
The chip selects are combinational from the address, `mem_en`, `psel` and the window flag. They are therefore due in the same cycle as the access. The window flag itself changes one edge after the closing bus cycle or after the settled press. A press reaches the window flag after `DEB_CYCLES`+3 edges and reaches `load_irq` one edge later. The power-up request comes on the first edge after reset.

The bench keeps a behavioural reference of the window flag, the debounce run length and the pending request, and advances it on every rising edge. It changes stimulus and compares all three outputs only at falling edges, after the design has settled. Direct checks also count the edges from button rise to the request and count the request pulses.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic {
    MAP_ROM_TOP    = 1'b0,
    MAP_ROM_BOTTOM = 1'b1
  } map_sel_e;

endpackage

// File: rtl/bmc_debounce.sv
module bmc_debounce #(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic press_o
);

  localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(DEB_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          level;
  logic          stable_q;
  logic [CW-1:0] run_q;
  logic          differs;
  logic          settle;

  assign level   = sync_q[1];
  assign differs = level != stable_q;
  assign settle  = differs && (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b00;
      stable_q <= 1'b0;
      run_q    <= '0;
      press_o  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      press_o <= settle && level;
      if (!differs) begin
        run_q <= '0;
      end else if (settle) begin
        stable_q <= level;
        run_q    <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_press_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |-> stable_q);
  p_press_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/bmc_restore_ctrl.sv
module bmc_restore_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic press_i,
  input  logic mem_en_i,
  input  logic psel_i,
  output logic restore_o,
  output logic load_irq_o
);

  logic por_pend_q;
  logic btn_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_pend_q <= 1'b1;
      btn_pend_q <= 1'b0;
      restore_o  <= 1'b1;
      load_irq_o <= 1'b0;
    end else begin
      por_pend_q <= 1'b0;
      btn_pend_q <= press_i;
      load_irq_o <= por_pend_q | btn_pend_q;
      if (press_i)
        restore_o <= 1'b1;
      else if (mem_en_i && psel_i)
        restore_o <= 1'b0;
    end
  end

  p_irq_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_irq_o |=> !load_irq_o);
  p_window_before_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    press_i |=> restore_o);
  p_irq_after_press_r7: assert property (@(posedge clk) disable iff (!rst_n)
    press_i |=> ##1 load_irq_o);
  p_psel_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_i && psel_i && !press_i) |=> !restore_o);

endmodule

// File: rtl/bmc_addr_decode.sv
module bmc_addr_decode
  import bmc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BITS = 10
) (
  input  logic              mem_en_i,
  input  logic              psel_i,
  input  logic              restore_i,
  input  map_sel_e          map_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_cs_o,
  output logic              ram_cs_o
);

  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0] hi;
  logic            in_win;
  logic            rom_hit;

  assign hi = addr_i[ADDR_W-1:WIN_BITS];

  always_comb begin
    unique case (map_i)
      MAP_ROM_BOTTOM: in_win = ~|hi;
      default:        in_win = &hi;
    endcase
  end

  assign rom_hit  = in_win && restore_i && !psel_i;
  assign rom_cs_o = mem_en_i && rom_hit;
  assign ram_cs_o = mem_en_i && !rom_hit;

endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
  import bmc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WIN_BITS   = 10,
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_btn,
  input  logic              map_low,
  input  logic              mem_en,
  input  logic              psel,
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              load_irq
);

  logic     press;
  logic     restore;
  map_sel_e map_sel;

  assign map_sel = map_sel_e'(map_low);

  bmc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (load_btn),
    .press_o (press)
  );

  bmc_restore_ctrl u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .press_i    (press),
    .mem_en_i   (mem_en),
    .psel_i     (psel),
    .restore_o  (restore),
    .load_irq_o (load_irq)
  );

  bmc_addr_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
    .mem_en_i  (mem_en),
    .psel_i    (psel),
    .restore_i (restore),
    .map_i     (map_sel),
    .addr_i    (addr),
    .rom_cs_o  (rom_cs),
    .ram_cs_o  (ram_cs)
  );

  p_cs_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));
  p_idle_no_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (!rom_cs && !ram_cs));
  p_psel_hides_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> !rom_cs);
  p_irq_with_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_irq |-> (restore || $past(press) || $past(restore)));

endmodule

// File: tb/sim_boot_map_ctrl.sv
`timescale 1ns/1ps
module sim_boot_map_ctrl;

  localparam int DEB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_btn = 1'b0;
  logic        map_low = 1'b0;
  logic        mem_en = 1'b0;
  logic        psel = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rom_cs, ram_cs, load_irq;

  always #2.5 clk = ~clk;

  boot_map_ctrl #(.ADDR_W(16), .WIN_BITS(10), .DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .load_btn(load_btn), .map_low(map_low),
    .mem_en(mem_en), .psel(psel), .addr(addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .load_irq(load_irq)
  );

  int    total = 0;
  int    bad = 0;
  bit    run_chk = 0;
  string cur_req = "R6";

  // behavioural reference state
  bit m_por = 1, m_pend = 0, m_press = 0, m_rest = 1, m_irq = 0;
  bit sq[$] = '{0, 0};
  bit stab = 0;
  int run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_por = 1; m_pend = 0; m_press = 0; m_rest = 1; m_irq = 0;
      sq = '{0, 0}; stab = 0; run = 0;
    end else begin
      bit nirq, lvl;
      nirq = m_por | m_pend;
      m_por = 0;
      m_pend = m_press;
      if (m_press) m_rest = 1;
      else if (mem_en && psel) m_rest = 0;
      lvl = sq.pop_front();
      sq.push_back(load_btn);
      m_press = 0;
      if (lvl == stab) run = 0;
      else begin
        run++;
        if (run == DEB) begin stab = lvl; run = 0; m_press = lvl; end
      end
      m_irq = nirq;
    end
  end

  task automatic chk(string req, logic got, logic exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit in_win(logic [15:0] a, logic low);
    return low ? (a < 16'h0400) : (a >= 16'hFC00);
  endfunction

  always @(negedge clk) begin
    #0.5;
    if (run_chk) begin
      bit er;
      er = mem_en && !psel && m_rest && in_win(addr, map_low);
      chk(cur_req, rom_cs, er, "rom_cs");
      chk(cur_req, ram_cs, mem_en && !er, "ram_cs");
      chk(cur_req, load_irq, m_irq, "load_irq");
      chk("R10", rom_cs && ram_cs, 1'b0, "exclusive");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(logic [15:0] a);
    addr = a;
    cyc(1);
  endtask

  int irq_seen;
  int edges;

  initial begin
    cyc(3);
    run_chk = 1;
    cur_req = "R6";
    mem_en = 0; addr = 16'hFFFC;
    cyc(2);
    chk("R1", load_irq, 1'b0, "reset state irq");
    rst_n = 1;
    cur_req = "R1";
    @(posedge clk); #1;
    chk("R1", load_irq, 1'b1, "power-up pulse");
    @(posedge clk); #1;
    chk("R1", load_irq, 1'b0, "power-up pulse ends");
    cyc(1);

    cur_req = "R2";
    mem_en = 1; map_low = 0; psel = 0;
    acc(16'hFC00); acc(16'hFFFC); acc(16'hFFFE); acc(16'hFBFE);
    acc(16'h0000); acc(16'h8000);
    #1 addr = 16'hFFFC; #0.5;
    chk("R2", rom_cs, 1'b1, "vector in window");

    cur_req = "R5";
    map_low = 1;
    acc(16'h0000); acc(16'h03FE); acc(16'h0400); acc(16'hFFFC);

    cur_req = "R6";
    mem_en = 0; map_low = 0;
    acc(16'hFFFC); acc(16'h1234);

    cur_req = "R3";
    psel = 1; addr = 16'hFFFC;
    cyc(2);
    mem_en = 1;
    #1 chk("R3", rom_cs, 1'b0, "psel hides rom");
    chk("R3", ram_cs, 1'b1, "psel gives ram");
    cyc(1);

    cur_req = "R4";
    psel = 0;
    acc(16'hFFFC); acc(16'hFC00);
    #1 chk("R4", rom_cs, 1'b0, "window stays closed");

    cur_req = "R8";
    load_btn = 1; cyc(DEB - 3); load_btn = 0;
    cyc(DEB + 6);
    load_btn = 1; cyc(2); load_btn = 0;
    cyc(DEB + 6);
    addr = 16'hFFFC; cyc(1);

    cur_req = "R7";
    irq_seen = 0; edges = 0;
    load_btn = 1;
    while (!load_irq && edges < 3 * DEB) begin
      @(posedge clk); #1; edges++;
    end
    chk("R7", (edges == DEB + 4), 1'b1, "edges to irq");
    if (edges != DEB + 4) $display("FAIL R7 edge count actual=%0d expected=%0d", edges, DEB + 4);
    repeat (DEB) begin
      if (load_irq) irq_seen++;
      @(posedge clk); #1;
    end
    chk("R7", (irq_seen == 1), 1'b1, "single pulse");
    chk("R7", rom_cs, 1'b1, "window reopened");

    cur_req = "R9";
    load_btn = 0;
    cyc(DEB + 8);
    #1 chk("R9", rom_cs, 1'b1, "release keeps window");

    cur_req = "R4";
    psel = 1; cyc(1); psel = 0;
    acc(16'hFFFE);

    run_chk = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule